// File: doc/BRIEF.md
# Strip Cluster Width Filter

This block looks at the binary hit pattern of one sensor layer in a single bunch crossing. Hits on disabled channels are removed first. The block then finds each run of adjacent hit strips and keeps only the narrow runs: those no wider than a limit that software selects. For every run it keeps, it raises one flag at the run's centre, on a grid with half-strip pitch. A later stage pairs these flags between layers to find track stubs. That pairing is not part of this block.

Each chip shares its two outermost cleaned hit bits at each edge with the chip next to it, and it takes the same bits from that chip. A run that crosses a chip boundary is therefore measured over its full width. Its flag appears only on the chip that owns the centre position, so it is reported exactly once. Only the centre flags are registered; the bits shared with the neighbours are combinational.

Top module: `strip_cluster_filter`

## Requirements
- R1: A channel whose `chan_off_i` bit is 1 counts as not hit, whatever its `hit_i` bit is. A flag is never raised at the integer position 2n of a disabled channel n.
- R2: An isolated hit on channel n (neighbours n-1 and n+1 empty) raises `centre_o[2n]` when `max_width_i` is 1, 2 or 3.
- R3: A run of exactly two hits on channels n and n+1 raises `centre_o[2n+1]` when `max_width_i` is 2 or 3.
- R4: A run of exactly three hits on channels n-1, n and n+1 raises `centre_o[2n]` only when `max_width_i` is 3.
- R5: A run of four or more adjacent hits raises no flag, whatever the setting.
- R6: A run wider than the value of `max_width_i` raises no flag. With setting 1, every odd position of `centre_o` stays 0.
- R7: With `max_width_i` = 0, `centre_o` is all zero.
- R8: `edge_lo_i[0]` and `edge_lo_i[1]` stand for channels -1 and -2. `edge_hi_i[0]` and `edge_hi_i[1]` stand for channels N and N+1. These bits take part in finding runs and measuring their width. A run whose centre position falls outside 0..2N-1 raises no flag.
- R9: `edge_lo_o[j]` equals the cleaned hit of channel j, and `edge_hi_o[j]` equals the cleaned hit of channel N-1-j, for j = 0 and 1. Both are combinational.
- R10: `centre_o` changes only at a clock edge. It reflects the inputs sampled at the edge that loads it, and it is all zero on the edge after `rst` is high.
- R11: A disabled channel inside a run of hits splits the run into two separate runs, and each is judged on its own width.
- R12: No two adjacent positions of `centre_o` are ever both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one edge per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NUM_CH | Raw binary hit per channel |
| chan_off_i | input | NUM_CH | 1 = channel disabled |
| max_width_i | input | 2 | Largest accepted run width: 0 off, 1, 2 or 3 |
| edge_lo_i | input | 2 | Cleaned hits of the lower neighbour chip's channels -1, -2 |
| edge_hi_i | input | 2 | Cleaned hits of the upper neighbour chip's channels N, N+1 |
| edge_lo_o | output | 2 | Cleaned hits of channels 0, 1 for the lower neighbour |
| edge_hi_o | output | 2 | Cleaned hits of channels N-1, N-2 for the upper neighbour |
| centre_o | output | 2*NUM_CH | Registered centre flags, half-strip grid |

## Verification
The bench uses an eight-channel instance. It sweeps every hit pattern against every combination of the four edge bits and every width setting, with four different channel-disable masks. Each result is compared with a run-scanning model that measures each run and places its centre arithmetically. Single hits, pairs, triples and wider runs are therefore all covered. The sweep distinguishes odd-width centres from even-width centres, and it separates the effect of the width limit from the effect of disabling channels. Directed cases add the following:
- a run that straddles each chip edge, both when its centre is owned by this chip and when it belongs to the neighbour;
- a disabled channel that splits a triple into two singles;
- a reset in the middle of the run.

// File: rtl/sclf_pkg.sv
package sclf_pkg;

    // Strips borrowed from each neighbour chip: enough to see one empty
    // strip beyond the widest accepted run whose centre is on this chip.
    localparam int unsigned MAX_RUN = 3;
    localparam int unsigned EDGE_W  = MAX_RUN / 2 + 1;

    typedef enum logic [1:0] {
        WSEL_OFF   = 2'd0,
        WSEL_ONE   = 2'd1,
        WSEL_TWO   = 2'd2,
        WSEL_THREE = 2'd3
    } width_sel_e;

    typedef struct packed {
        logic single;
        logic pair;
        logic triple;
    } accept_t;

    function automatic accept_t decode_width(width_sel_e sel);
        accept_t a;
        a.single = (sel != WSEL_OFF);
        a.pair   = (sel == WSEL_TWO) || (sel == WSEL_THREE);
        a.triple = (sel == WSEL_THREE);
        return a;
    endfunction

endpackage

// File: rtl/sclf_clean.sv
module sclf_clean
    import sclf_pkg::*;
#(
    parameter int unsigned NUM_CH = 127,
    localparam int unsigned EXT_W = NUM_CH + 2 * EDGE_W
) (
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] chan_off_i,
    input  logic [EDGE_W-1:0] edge_lo_i,
    input  logic [EDGE_W-1:0] edge_hi_i,
    output logic [EXT_W-1:0]  ext_o,
    output logic [EDGE_W-1:0] edge_lo_o,
    output logic [EDGE_W-1:0] edge_hi_o
);

    logic [NUM_CH-1:0] clean;

    always_comb begin
        clean = hit_i & ~chan_off_i;
        ext_o = '0;
        ext_o[EDGE_W +: NUM_CH] = clean;
        for (int j = 0; j < EDGE_W; j++) begin
            ext_o[EDGE_W - 1 - j]   = edge_lo_i[j];
            ext_o[EDGE_W + NUM_CH + j] = edge_hi_i[j];
            edge_lo_o[j] = clean[j];
            edge_hi_o[j] = clean[NUM_CH - 1 - j];
        end
    end

endmodule

// File: rtl/sclf_finder.sv
module sclf_finder
    import sclf_pkg::*;
#(
    parameter int unsigned NUM_CH = 127,
    localparam int unsigned EXT_W = NUM_CH + 2 * EDGE_W,
    localparam int unsigned POS_W = 2 * NUM_CH
) (
    input  logic [EXT_W-1:0] ext_i,
    input  accept_t          acc_i,
    output logic [POS_W-1:0] centre_o
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_strip
        localparam int unsigned P = n + EDGE_W;

        logic lone, trio, duo;

        // odd-width run centred on strip n
        assign lone = ext_i[P] & ~ext_i[P-1] & ~ext_i[P+1];
        assign trio = ext_i[P-1] & ext_i[P] & ext_i[P+1]
                    & ~ext_i[P-2] & ~ext_i[P+2];
        // even-width run on strips n, n+1
        assign duo  = ext_i[P] & ext_i[P+1] & ~ext_i[P-1] & ~ext_i[P+2];

        assign centre_o[2*n]     = (acc_i.single & lone) | (acc_i.triple & trio);
        assign centre_o[2*n + 1] = acc_i.pair & duo;
    end

endmodule

// File: rtl/strip_cluster_filter.sv
module strip_cluster_filter
    import sclf_pkg::*;
#(
    parameter int unsigned NUM_CH = 127,
    localparam int unsigned EXT_W = NUM_CH + 2 * EDGE_W,
    localparam int unsigned POS_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] chan_off_i,
    input  logic [1:0]        max_width_i,
    input  logic [EDGE_W-1:0] edge_lo_i,
    input  logic [EDGE_W-1:0] edge_hi_i,
    output logic [EDGE_W-1:0] edge_lo_o,
    output logic [EDGE_W-1:0] edge_hi_o,
    output logic [POS_W-1:0]  centre_o
);

    logic [EXT_W-1:0] ext;
    logic [POS_W-1:0] centre_d;
    accept_t          acc;

    assign acc = decode_width(width_sel_e'(max_width_i));

    sclf_clean #(.NUM_CH(NUM_CH)) u_clean (
        .hit_i      (hit_i),
        .chan_off_i (chan_off_i),
        .edge_lo_i  (edge_lo_i),
        .edge_hi_i  (edge_hi_i),
        .ext_o      (ext),
        .edge_lo_o  (edge_lo_o),
        .edge_hi_o  (edge_hi_o)
    );

    sclf_finder #(.NUM_CH(NUM_CH)) u_finder (
        .ext_i    (ext),
        .acc_i    (acc),
        .centre_o (centre_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            centre_o <= '0;
        end else begin
            centre_o <= centre_d;
        end
    end

endmodule

// File: rtl/sclf_checker.sv
module sclf_checker #(
    parameter int unsigned NUM_CH = 127,
    localparam int unsigned POS_W = 2 * NUM_CH
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] chan_off_i,
    input logic [1:0]        max_width_i,
    input logic [POS_W-1:0]  centre_o
);

    logic [NUM_CH-1:0] even_v, odd_v;

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            even_v[n] = centre_o[2*n];
            odd_v[n]  = centre_o[2*n + 1];
        end
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> centre_o == '0);

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (rst)
        max_width_i == 2'd0 |=> centre_o == '0);

    assert_single_no_half_R6: assert property (@(posedge clk) disable iff (rst)
        max_width_i == 2'd1 |=> odd_v == '0);

    assert_disabled_no_centre_R1: assert property (@(posedge clk) disable iff (rst)
        (|chan_off_i) |=> (even_v & $past(chan_off_i)) == '0);

    assert_flags_apart_R12: assert property (@(posedge clk) disable iff (rst)
        (centre_o & (centre_o >> 1)) == '0);

endmodule

bind strip_cluster_filter sclf_checker #(.NUM_CH(NUM_CH)) u_sclf_checker (
    .clk         (clk),
    .rst         (rst),
    .chan_off_i  (chan_off_i),
    .max_width_i (max_width_i),
    .centre_o    (centre_o)
);

// File: tb/strip_cluster_filter_bench.sv
module strip_cluster_filter_bench;

    localparam int N = 8;
    localparam int P = 2 * N;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] hit, off;
    logic [1:0]   wsel, lo_i, hi_i, lo_o, hi_o;
    logic [P-1:0] centre;
    logic [P-1:0] prev_exp;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    strip_cluster_filter #(.NUM_CH(N)) u_strip_cluster_filter (
        .clk(clk), .rst(rst), .hit_i(hit), .chan_off_i(off),
        .max_width_i(wsel), .edge_lo_i(lo_i), .edge_hi_i(hi_i),
        .edge_lo_o(lo_o), .edge_hi_o(hi_o), .centre_o(centre)
    );

    // Scan runs of the extended cleaned vector; centre = 2*start + width - 1.
    function automatic logic [P-1:0] model(logic [N-1:0] h, logic [N-1:0] m,
                                           logic [1:0] lo, logic [1:0] hi,
                                           logic [1:0] w);
        logic [N+3:0] e;
        logic [P-1:0] r;
        int s, len, pos;
        r = '0; s = 0; len = 0;
        e[0] = lo[1]; e[1] = lo[0];
        for (int c = 0; c < N; c++) e[c+2] = h[c] & ~m[c];
        e[N+2] = hi[0]; e[N+3] = hi[1];
        for (int i = 0; i <= N + 4; i++) begin
            if (i < N + 4 && e[i]) begin
                if (len == 0) s = i;
                len++;
            end else begin
                if (len > 0 && len <= int'(w)) begin
                    pos = 2 * (s - 2) + len - 1;
                    if (pos >= 0 && pos < P) r[pos] = 1'b1;
                end
                len = 0;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [P-1:0] got, logic [P-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; result checked one falling edge later.
    task automatic drive(string tag, logic [N-1:0] h, logic [N-1:0] m,
                         logic [1:0] lo, logic [1:0] hi, logic [1:0] w);
        logic [N-1:0] c;
        logic [P-1:0] exp;
        hit = h; off = m; lo_i = lo; hi_i = hi; wsel = w;
        c = h & ~m;
        exp = model(h, m, lo, hi, w);
        #1;
        check("R9 low edge", P'(lo_o), P'({c[1], c[0]}));
        check("R9 high edge", P'(hi_o), P'({c[N-2], c[N-1]}));
        check("R10 held until edge", centre, prev_exp);
        @(negedge clk);
        check(tag, centre, exp);
        prev_exp = exp;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; hit = '0; off = '0; wsel = 2'd3; lo_i = '0; hi_i = '0;
        prev_exp = '0;
        repeat (3) @(negedge clk);
        check("R10 reset state", centre, '0);
        rst = 1'b0;

        drive("R2 single", 8'b0000_1000, '0, 2'b00, 2'b00, 2'd1);
        check("R2 bit6", centre, 16'h0040);
        drive("R3 pair", 8'b0001_1000, '0, 2'b00, 2'b00, 2'd2);
        check("R3 bit7", centre, 16'h0080);
        drive("R4 triple", 8'b0001_1100, '0, 2'b00, 2'b00, 2'd3);
        check("R4 bit6", centre, 16'h0040);
        drive("R4 triple at w2", 8'b0001_1100, '0, 2'b00, 2'b00, 2'd2);
        check("R4 rejected at w2", centre, '0);
        drive("R5 four wide", 8'b0001_1110, '0, 2'b00, 2'b00, 2'd3);
        check("R5 none", centre, '0);
        drive("R6 pair at w1", 8'b0001_1000, '0, 2'b00, 2'b00, 2'd1);
        check("R6 none", centre, '0);
        drive("R7 off", 8'b0100_0010, '0, 2'b00, 2'b00, 2'd0);
        check("R7 none", centre, '0);
        drive("R8 low triple", 8'b0000_0011, '0, 2'b01, 2'b00, 2'd3);
        check("R8 bit0", centre, 16'h0001);
        drive("R8 low pair owned below", 8'b0000_0001, '0, 2'b01, 2'b00, 2'd3);
        check("R8 none", centre, '0);
        drive("R8 low four wide", 8'b0000_0011, '0, 2'b11, 2'b00, 2'd3);
        check("R8 width4", centre, '0);
        drive("R8 high pair", 8'b1000_0000, '0, 2'b00, 2'b01, 2'd2);
        check("R8 bit15", centre, 16'h8000);
        drive("R11 split triple", 8'b0001_1100, 8'b0000_1000, 2'b00, 2'b00, 2'd3);
        check("R11 bits4,8", centre, 16'h0110);
        drive("R1 disabled only hit", 8'b0000_1000, 8'b0000_1000, 2'b00, 2'b00, 2'd1);
        check("R1 none", centre, '0);

        for (int mi = 0; mi < 4; mi++) begin
            logic [N-1:0] mk;
            mk = (mi == 0) ? 8'h00 : (mi == 1) ? 8'h10 : (mi == 2) ? 8'h81 : 8'h5A;
            for (int h = 0; h < 256; h++)
                for (int nb = 0; nb < 16; nb++)
                    for (int w = 0; w < 4; w++)
                        drive("R2-sweep", N'(h), mk, nb[1:0], nb[3:2], w[1:0]);
        end

        drive("R10 before reset", 8'b0000_0100, '0, 2'b00, 2'b00, 2'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset", centre, '0);
        rst = 1'b0;
        prev_exp = '0;
        drive("R2 after reset", 8'b0010_0000, '0, 2'b00, 2'b00, 2'd1);

        summary();
        $finish;
    end

endmodule